// File: doc/BRIEF.md
# Serial Link Self-Test Error Checker

This block sits on the receive side of a serial link and judges a built-in self test. During a test run the far-end transmitter replaces its payload with a constant all-zeroes pattern. After descrambling, every recovered parallel word should therefore be zero. The checker compares each recovered word against zero, but only while the test is enabled and the clock and data recovery stage reports lock. It adds up the mismatching bits in a saturating counter and drives a pass flag that falls as soon as an error appears.

A test run follows a fixed order. The receiver enables the test first and waits. The transmitter then enters its test mode and sends the pattern. Finally the receiver leaves test mode and reads the verdict. A run begins on the rising edge of the test enable, which clears the counter and re-arms the pass flag. When the enable drops, the counter and the flag freeze. They keep the verdict of the finished run until the next run begins.

Top module: `linkBistChecker`

## Requirements
- R1: After reset, `passOut` is 1 and `errCount` is 0.
- R2: In the cycle after a cycle where `bistEn` is 1 and was 0 in the cycle before, `errCount` is 0 and `passOut` is 1. The word present in that entry cycle is not compared.
- R3: In any other cycle with `bistEn` and `rxLock` both 1, the number of 1 bits in `rxWord` is added to `errCount`. The new value is visible in the following cycle.
- R4: While `rxLock` is 0, recovered words are ignored and `errCount` and `passOut` do not change.
- R5: `passOut` goes to 0 in the cycle after the first compared word that is nonzero. It stays 0 until the next run begins (R2).
- R6: `errCount` saturates at 2^CNT_W-1 and never wraps.
- R7: While `bistEn` is 0, `errCount` and `passOut` hold the result of the last run, whatever the values of `rxWord` and `rxLock`.
- R8: A compared word that is all zeroes changes neither `errCount` nor `passOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bistEn | input | 1 | Self-test enable; a rising edge starts a run |
| rxLock | input | 1 | Lock indication from clock and data recovery |
| rxWord | input | DATA_W | Descrambled recovered word |
| passOut | output | 1 | 1 while no error has been seen in the current or last run |
| errCount | output | CNT_W | Saturating count of bit errors |

## Verification
The hardest state to reach is the saturated counter. Reaching it needs dozens of compared words that carry many set bits, inside a single run that is never restarted. The stimulus drives runs of all-ones words, so the count crosses its maximum partway through one word and then keeps receiving errors while pinned. A behavioural model tracks the expected count and flag on every clock. Around that model, the stimulus mixes garbage words arriving before lock, garbage words in the entry cycle, and garbage words while the test is idle.

// File: rtl/lbc_pkg.sv
package lbc_pkg;
  typedef struct packed {
    logic clearCnt;
    logic checkEn;
  } ctrlStrobes_t;
endpackage

// File: rtl/lbcControl.sv
module lbcControl
  import lbc_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         bistEn,
  input  logic         rxLock,
  output ctrlStrobes_t strobes
);
  logic bistPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bistPrev <= 1'b0;
    else       bistPrev <= bistEn;
  end

  // entry cycle clears; comparison only on later locked cycles
  always_comb begin
    strobes.clearCnt = bistEn & ~bistPrev;
    strobes.checkEn  = bistEn & bistPrev & rxLock;
  end
endmodule

// File: rtl/lbcDatapath.sv
module lbcDatapath
  import lbc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] rxWord,
  output logic              passOut,
  output logic [CNT_W-1:0]  errCount
);
  localparam int PC_W  = $clog2(DATA_W + 1);
  localparam int SUM_W = ((CNT_W > PC_W) ? CNT_W : PC_W) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [PC_W-1:0]  bitErrs;
  logic [SUM_W-1:0] sumWide;
  logic [CNT_W-1:0] nextCnt;

  always_comb begin
    bitErrs = '0;
    for (int i = 0; i < DATA_W; i++) bitErrs = bitErrs + PC_W'(rxWord[i]);
  end

  always_comb begin
    sumWide = SUM_W'(errCount) + SUM_W'(bitErrs);
    if (sumWide > SUM_W'(CNT_MAX)) nextCnt = CNT_MAX;
    else                          nextCnt = sumWide[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errCount <= '0;
      passOut  <= 1'b1;
    end else if (strobes.clearCnt) begin
      errCount <= '0;
      passOut  <= 1'b1;
    end else if (strobes.checkEn) begin
      errCount <= nextCnt;
      if (bitErrs != '0) passOut <= 1'b0;
    end
  end

  AST_CLEAR_ON_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearCnt |=> (errCount == '0) && passOut); // R2
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (!passOut && !strobes.clearCnt) |=> !passOut); // R5
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    ((errCount == CNT_MAX) && !strobes.clearCnt) |=> (errCount == CNT_MAX)); // R6
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.checkEn && !strobes.clearCnt) |=> ($stable(errCount) && $stable(passOut))); // R7
  AST_COUNT_MONOTONIC: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.clearCnt) |=> (errCount >= $past(errCount))); // R3
endmodule

// File: rtl/linkBistChecker.sv
module linkBistChecker
  import lbc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bistEn,
  input  logic              rxLock,
  input  logic [DATA_W-1:0] rxWord,
  output logic              passOut,
  output logic [CNT_W-1:0]  errCount
);
  ctrlStrobes_t strobes;

  lbcControl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .bistEn  (bistEn),
    .rxLock  (rxLock),
    .strobes (strobes)
  );

  lbcDatapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) data_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .rxWord   (rxWord),
    .passOut  (passOut),
    .errCount (errCount)
  );
endmodule

// File: tb/linkBistChecker_tb_top.sv
module linkBistChecker_tb_top;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 8;
  localparam int MAXC   = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bistEn = 1'b0;
  logic rxLock = 1'b0;
  logic [DATA_W-1:0] rxWord = '0;
  logic passOut;
  logic [CNT_W-1:0] errCount;

  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;
  int mCnt = 0;
  bit mPass = 1'b1;
  bit mPrev = 1'b0;
  string curTag = "R1";

  always #10 clk = ~clk;

  linkBistChecker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .bistEn(bistEn), .rxLock(rxLock),
    .rxWord(rxWord), .passOut(passOut), .errCount(errCount)
  );

  // behavioural reference
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt <= 0; mPass <= 1'b1; mPrev <= 1'b0;
    end else begin
      mPrev <= bistEn;
      if (bistEn && !mPrev) begin
        mCnt <= 0; mPass <= 1'b1;
      end else if (bistEn && rxLock) begin
        mCnt <= (mCnt + $countones(rxWord) > MAXC) ? MAXC : mCnt + $countones(rxWord);
        if (rxWord != '0) mPass <= 1'b0;
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit b, input bit l, input logic [DATA_W-1:0] w, input string tag);
    @(negedge clk);
    check({curTag, " pass"}, int'(passOut), int'(mPass));
    check({curTag, " count"}, int'(errCount), mCnt);
    bistEn = b; rxLock = l; rxWord = w; curTag = tag;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset pass", int'(passOut), 1);
    check("R1 reset count", int'(errCount), 0);
    rstN = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b0, i[0], 16'hA5A5, "R7");
    step(1'b1, 1'b1, 16'hFFFF, "R2");          // entry word ignored
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 16'h0F0F, "R4");
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 16'h0000, "R8");
    step(1'b1, 1'b1, 16'h0101, "R3,R5");
    step(1'b1, 1'b1, 16'h0000, "R5,R8");
    step(1'b1, 1'b1, 16'h8001, "R3");
    step(1'b1, 1'b0, 16'h7777, "R4");
    step(1'b0, 1'b1, 16'h3333, "R7");
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 16'hFFFF, "R7");
    @(negedge clk);
    check("R5 held fail", int'(passOut), 0);
    check("R3 held count", int'(errCount), 4);
    step(1'b1, 1'b1, 16'h0001, "R2");
    for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 16'h0000, "R8");
    step(1'b0, 1'b0, 16'h00FF, "R7");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 16'h00FF, "R7");
    @(negedge clk);
    check("R2 clean run pass", int'(passOut), 1);
    check("R2 clean run count", int'(errCount), 0);
    step(1'b1, 1'b1, 16'h0000, "R2");
    for (int i = 0; i < 15; i++) step(1'b1, 1'b1, 16'hFFFF, "R3");
    step(1'b1, 1'b1, 16'h0FFF, "R6");
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 16'hFFFF, "R6");
    step(1'b0, 1'b1, 16'h0000, "R6");
    @(negedge clk);
    check("R6 saturated", int'(errCount), MAXC);
    check("R5 saturated run fail", int'(passOut), 0);
    step(1'b0, 1'b0, 16'h0000, "R7");
    step(1'b0, 1'b0, 16'h0000, "R7");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule